// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects up to fifteen interrupt request lines (numbered 1 to 15) for a single processor and reduces them to one 4-bit interrupt number. A rising edge on a request line latches the request. Software can also raise any line through a force register. A mask decides which latched or forced lines may reach the processor. A per-line priority bit puts each line in a high group or a low group. The processor sees the highest-numbered active line of the high group when that group has any active line, and otherwise the highest-numbered active line of the low group.

When the processor takes an interrupt it returns the interrupt number on an acknowledge port. The block then drops that line's latched request and its force bit. Software configures and inspects the block through a flat 32-bit word bus with byte addresses in a 256-byte window. Writes are accepted in one cycle and reads are combinational. Lines marked for broadcast deliver their requests into the force register instead of the pending register.

The block has no sequencing of its own. All behaviour is per-cycle register update plus a combinational priority selection, so no state machine appears.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero, and `irq_level` is 0.
- R2: Bit 0 of the priority, force, broadcast, mask and pending registers is always zero; written bit 0 and bits above 15 are dropped. The extended register at 0xC0 keeps only written bits 3:0.
- R3: A line is active when its bit is set in (pending OR force) AND mask. `irq_level` is the highest active line number in the selected group, or 0 when none is active. It reflects register contents written at a clock edge before the following edge.
- R4: Priority bit 1 means high group and 0 means low group. While any high-group line is active, low-group lines are not presented.
- R5: Register offsets: priority 0x00, pending 0x04, force 0x08 and 0x80 (same register), clear 0x0C, status 0x10, broadcast 0x14, mask 0x40, extended 0xC0. Each register reads back its stored value.
- R6: Reads of 0x0C and 0x10 return zero. Writes to 0x04 and 0x10 change no register.
- R7: Writing to 0x0C clears each pending bit whose written bit (15:1) is 1 and leaves the others unchanged.
- R8: A write to 0x80 takes bits 15:1 as set bits and bits 31:17 as clear bits (clear bit 16+n for line n). The new force value is (old OR set) AND NOT clear, so clear wins.
- R9: A write to 0x08 replaces the whole force register with written bits 15:1.
- R10: A 0-to-1 transition on `irq_req[n]` sets force bit n when broadcast bit n is 1, and pending bit n otherwise. A request held high does not set the bit again.
- R11: A cycle with `ack_valid` high clears pending and force bit `ack_num` (4-bit, so taken modulo 16). `ack_num` 0 clears nothing.
- R12: Within one cycle the bus write is applied first, then new request edges, then the acknowledge clear. A request edge therefore survives a clear write, and an acknowledge of the same line wins over a request edge.
- R13: Any address not listed in R5 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request lines; bit 0 unused |
| ack_valid | input | 1 | Processor acknowledges an interrupt this cycle |
| ack_num | input | 4 | Number of the acknowledged interrupt |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_level | output | 4 | Interrupt number presented to the processor, 0 for none |

## Verification
The priority selection is driven by every ordered pair of lines raised through the force register. For each pair the bench tries four priority patterns (all low, only one line high, only the other line high, all high) and two mask patterns. This separates "highest number wins" from "high group wins", and shows whether the mask removes the winner. Single-line request sweeps then show that edges latch into pending in line order, and acknowledge sweeps from the top line downwards show that each acknowledge removes exactly one line. Directed cases check that set and clear in one force write resolve to clear, that broadcast lines land in force rather than pending, and that same-cycle request, clear-write and acknowledge combinations resolve in the stated order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned WIN_AW = 8;

    typedef enum logic [3:0] {
        SEL_PRIO,
        SEL_PEND,
        SEL_FALIAS,
        SEL_CLEAR,
        SEL_STATUS,
        SEL_BCAST,
        SEL_MASK,
        SEL_FORCE,
        SEL_EXT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [WIN_AW-1:0] a);
        reg_sel_e s;
        case (a)
            8'h00:   s = SEL_PRIO;
            8'h04:   s = SEL_PEND;
            8'h08:   s = SEL_FALIAS;
            8'h0C:   s = SEL_CLEAR;
            8'h10:   s = SEL_STATUS;
            8'h14:   s = SEL_BCAST;
            8'h40:   s = SEL_MASK;
            8'h80:   s = SEL_FORCE;
            8'hC0:   s = SEL_EXT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    output logic [LINES-1:0] rise
);
    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req;
    end

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            if (g == 0) begin : g_none
                assign rise[g] = 1'b0;
            end else begin : g_det
                assign rise[g] = req[g] & ~prev_q[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned LINES = 16,
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] frc,
    input  logic [LINES-1:0] msk,
    input  logic [LINES-1:0] prio,
    output logic [LW-1:0]    level
);
    logic [LINES-1:0] act;
    logic [LINES-1:0] grp_hi;
    logic [LINES-1:0] grp_lo;
    logic [LINES-1:0] chosen;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_act
            assign act[g]    = (pend[g] | frc[g]) & msk[g];
            assign grp_hi[g] = act[g] & prio[g];
            assign grp_lo[g] = act[g] & ~prio[g];
        end
    endgenerate

    assign chosen = (|grp_hi) ? grp_hi : grp_lo;

    always_comb begin
        level = '0;
        for (int i = 1; i < LINES; i++) begin
            if (chosen[i]) level = LW'(i);
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EXT_W  = 4,
    localparam int unsigned LW    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  rise,
    input  logic              ack_valid,
    input  logic [LW-1:0]     ack_num,
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LINES-1:0]  pend_q,
    output logic [LINES-1:0]  frc_q,
    output logic [LINES-1:0]  msk_q,
    output logic [LINES-1:0]  prio_q
);
    localparam logic [LINES-1:0] LINE_KEEP = {{(LINES-1){1'b1}}, 1'b0};

    logic [LINES-1:0] bc_q;
    logic [EXT_W-1:0] ext_q;

    logic [LINES-1:0] pend_d, frc_d, msk_d, prio_d, bc_d;
    logic [EXT_W-1:0] ext_d;
    logic [LINES-1:0] wr_bits, wr_clr, ack_vec, frc_wr;
    reg_sel_e         wsel, rsel;

    assign wsel    = decode_addr(bus_addr);
    assign rsel    = wsel;
    assign wr_bits = bus_wdata[LINES-1:0] & LINE_KEEP;
    assign wr_clr  = bus_wdata[LINES +: LINES] & LINE_KEEP;
    assign ack_vec = ack_valid ? (LINES'(1) << ack_num) & LINE_KEEP : '0;

    always_comb begin
        pend_d = pend_q;
        frc_wr = frc_q;
        msk_d  = msk_q;
        prio_d = prio_q;
        bc_d   = bc_q;
        ext_d  = ext_q;
        if (bus_we) begin
            unique case (wsel)
                SEL_PRIO:   prio_d = wr_bits;
                SEL_FALIAS: frc_wr = wr_bits;
                SEL_CLEAR:  pend_d = pend_q & ~wr_bits;
                SEL_BCAST:  bc_d   = wr_bits;
                SEL_MASK:   msk_d  = wr_bits;
                SEL_FORCE:  frc_wr = (frc_q | wr_bits) & ~wr_clr;
                SEL_EXT:    ext_d  = bus_wdata[EXT_W-1:0];
                SEL_PEND, SEL_STATUS, SEL_NONE: ;
                default: ;
            endcase
        end
        pend_d = (pend_d | (rise & ~bc_q)) & ~ack_vec;
        frc_d  = (frc_wr | (rise & bc_q)) & ~ack_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            frc_q  <= '0;
            msk_q  <= '0;
            prio_q <= '0;
            bc_q   <= '0;
            ext_q  <= '0;
        end else begin
            pend_q <= pend_d;
            frc_q  <= frc_d;
            msk_q  <= msk_d;
            prio_q <= prio_d;
            bc_q   <= bc_d;
            ext_q  <= ext_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            SEL_PRIO:              bus_rdata = DATA_W'(prio_q);
            SEL_PEND:              bus_rdata = DATA_W'(pend_q);
            SEL_FALIAS, SEL_FORCE: bus_rdata = DATA_W'(frc_q);
            SEL_BCAST:             bus_rdata = DATA_W'(bc_q);
            SEL_MASK:              bus_rdata = DATA_W'(msk_q);
            SEL_EXT:               bus_rdata = DATA_W'(ext_q);
            SEL_CLEAR, SEL_STATUS, SEL_NONE: bus_rdata = '0;
            default:               bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned EXT_W  = 4,
    localparam int unsigned LW    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_req,
    input  logic              ack_valid,
    input  logic [LW-1:0]     ack_num,
    input  logic              bus_we,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LW-1:0]     irq_level
);
    logic [LINES-1:0] rise_w;
    logic [LINES-1:0] pend_w, frc_w, msk_w, prio_w;

    irqc_edge #(.LINES(LINES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (irq_req),
        .rise (rise_w)
    );

    irqc_regs #(.LINES(LINES), .DATA_W(DATA_W), .EXT_W(EXT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_w),
        .ack_valid(ack_valid),
        .ack_num  (ack_num),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pend_q   (pend_w),
        .frc_q    (frc_w),
        .msk_q    (msk_w),
        .prio_q   (prio_w)
    );

    irqc_prio #(.LINES(LINES)) u_prio (
        .pend (pend_w),
        .frc  (frc_w),
        .msk  (msk_w),
        .prio (prio_w),
        .level(irq_level)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LW    = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_valid,
    input logic [LW-1:0]     ack_num,
    input logic [7:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  pend,
    input logic [LINES-1:0]  frc,
    input logic [LINES-1:0]  msk,
    input logic [LINES-1:0]  prio,
    input logic [LW-1:0]     irq_level
);
    logic [LINES-1:0] act;
    assign act = (pend | frc) & msk;

    AST_NO_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] == 1'b0) && (frc[0] == 1'b0) && (msk[0] == 1'b0)); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (irq_level == '0)); // R3

    AST_LEVEL_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> act[irq_level]); // R3

    AST_HIGH_GROUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & prio) != '0) |-> prio[irq_level]); // R4

    AST_ACK_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (pend[$past(ack_num)] == 1'b0) && (frc[$past(ack_num)] == 1'b0)); // R11

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == 8'h0C) || (bus_addr == 8'h10)) |-> (bus_rdata == '0)); // R6
endmodule

bind irqc_top irqc_chk #(.LINES(LINES), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_valid(ack_valid),
    .ack_num  (ack_num),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .pend     (pend_w),
    .frc      (frc_w),
    .msk      (msk_w),
    .prio     (prio_w),
    .irq_level(irq_level)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .ack_valid(ack_valid), .ack_num(ack_num),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_level(irq_level)
    );

    function automatic int exp_level(input int pend, input int frc, input int msk, input int prio);
        int act, hi, sel, r;
        act = (pend | frc) & msk & 32'hFFFE;
        hi  = act & prio;
        sel = (hi != 0) ? hi : (act & ~prio);
        r = 0;
        for (int i = 1; i < 16; i++) if (sel[i]) r = i;
        return r;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input int exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        cmp(tag, int'(bus_rdata), exp);
    endtask

    task automatic pulse(input logic [15:0] r);
        @(negedge clk);
        irq_req = r;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic ack(input int n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = 4'(n);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic lvl(input string tag, input int exp);
        #1;
        cmp(tag, int'(irq_level), exp);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over the whole window
        for (int a = 0; a < 256; a += 4) rd("R1 reset read", 8'(a), 0);
        lvl("R1 reset level", 0);

        // R2 / R5: bit cleanup and readback
        wr(8'h00, 32'hFFFF_FFFF); rd("R2 R5 prio", 8'h00, 32'hFFFE);
        wr(8'h14, 32'hFFFF_FFFF); rd("R2 R5 bcast", 8'h14, 32'hFFFE);
        wr(8'h40, 32'hFFFF_FFFF); rd("R2 R5 mask", 8'h40, 32'hFFFE);
        wr(8'h08, 32'hFFFF_FFFF); rd("R2 R9 alias", 8'h08, 32'hFFFE);
        rd("R5 force at 0x80", 8'h80, 32'hFFFE);
        wr(8'hC0, 32'hFFFF_FFFF); rd("R2 ext", 8'hC0, 32'hF);
        wr(8'h00, 0); wr(8'h14, 0); wr(8'h08, 0); wr(8'hC0, 0);

        // R10 / R3: single-line edges latch into pending in order
        for (int n = 1; n < 16; n++) begin
            pulse(16'(1 << n));
            lvl("R10 R3 edge level", n);
        end
        rd("R10 pending all", 8'h04, 32'hFFFE);

        // R6 / R13: read-zero and ignored writes
        wr(8'h04, 0);            rd("R6 pending ro", 8'h04, 32'hFFFE);
        wr(8'h10, 32'hFFFF_FFFF); rd("R6 status", 8'h10, 0);
        rd("R6 clear reads zero", 8'h0C, 0);
        wr(8'h44, 32'hFFFF);     rd("R13 unmapped", 8'h44, 0);
        rd("R13 mask kept", 8'h40, 32'hFFFE);
        wr(8'h18, 32'hFFFF);     rd("R13 unmapped 18", 8'h18, 0);

        // R7: write-one-to-clear
        wr(8'h0C, 32'h0000_80A5); rd("R7 w1c", 8'h04, 32'h7F5A);
        lvl("R7 level", 14);
        wr(8'h0C, 32'hFFFF);     rd("R7 clear all", 8'h04, 0);
        lvl("R7 none", 0);

        // R10: held request does not retrigger
        @(negedge clk); irq_req = 16'h0008;
        repeat (2) @(negedge clk);
        wr(8'h0C, 32'h0008);
        repeat (3) @(negedge clk);
        rd("R10 held no retrigger", 8'h04, 0);
        @(negedge clk); irq_req = '0;

        // R11: acknowledge sweep from the top
        wr(8'h08, 32'hFFFE);
        for (int n = 1; n < 16; n++) pulse(16'(1 << n));
        ack(0); rd("R11 ack 0 no effect", 8'h04, 32'hFFFE);
        for (int n = 15; n >= 1; n--) begin
            ack(n);
            lvl("R11 ack level", n - 1);
        end
        rd("R11 pending empty", 8'h04, 0);
        rd("R11 force empty", 8'h08, 0);

        // R3 / R4: pair sweep through force alias
        for (int i = 1; i < 16; i++) begin
            for (int j = 1; j < 16; j++) begin
                int f, top, pr, mk;
                f = (1 << i) | (1 << j);
                top = (i > j) ? i : j;
                wr(8'h08, 32'(f));
                for (int p = 0; p < 4; p++) begin
                    pr = (p == 0) ? 0 : (p == 1) ? (1 << i) : (p == 2) ? (1 << j) : 32'hFFFE;
                    wr(8'h00, 32'(pr));
                    for (int m = 0; m < 2; m++) begin
                        mk = (m == 0) ? 32'hFFFE : (32'hFFFE & ~(1 << top));
                        wr(8'h40, 32'(mk));
                        lvl("R3 R4 pair", exp_level(0, f, mk, pr));
                    end
                end
            end
        end
        wr(8'h00, 0); wr(8'h40, 32'hFFFE); wr(8'h08, 0);

        // R8: set/clear in one write, clear wins
        wr(8'h08, 32'h00F0);
        wr(8'h80, 32'h0030_0300); rd("R8 set clear", 8'h80, 32'h03C0);
        wr(8'h80, 32'h0200_0200); rd("R8 clear wins", 8'h80, 32'h01C0);
        wr(8'h08, 0);             rd("R9 alias replace", 8'h80, 0);

        // R10: broadcast lines go to force
        wr(8'h14, 32'h0040);
        pulse(16'h0040);
        rd("R10 bcast force", 8'h08, 32'h0040);
        rd("R10 bcast no pend", 8'h04, 0);
        lvl("R10 bcast level", 6);
        ack(6); rd("R11 ack force", 8'h08, 0);
        wr(8'h14, 0);

        // R12: same-cycle ordering
        @(negedge clk); irq_req = 16'h0020; ack_valid = 1'b1; ack_num = 4'd5;
        @(negedge clk); irq_req = '0; ack_valid = 1'b0;
        rd("R12 ack beats edge", 8'h04, 0);
        @(negedge clk); irq_req = 16'h0010; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0010;
        @(negedge clk); irq_req = '0; bus_we = 1'b0; bus_addr = 8'hFC;
        rd("R12 edge beats clear", 8'h04, 32'h0010);
        lvl("R12 level", 4);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule